// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block holds an 8-bit timer/counter and a watchdog timeout counter. Both draw on one programmable power-of-two prescaler, and a single control byte decides which of the two owns it. The timer counts either a free internal instruction-cycle tick or edges of an external pin. The external pin passes through a synchroniser, and either its rising or its falling edge can be chosen. The consumer that does not own the prescaler counts its own events undivided. An undivided timer is therefore obtained by handing the prescaler to the watchdog.

Software reaches the block through a simple byte-wide register port that selects either the control byte or the timer value. Writes take effect on the next clock and reads are combinational. The timer wraps and raises a sticky overflow flag. The watchdog raises a one-cycle timeout pulse when it overflows, unless it has been cleared first. Clearing the watchdog, writing the timer, or moving the prescaler from one consumer to the other empties the prescaler's partial count, so a consumer never inherits a stale fraction of a period.

Top module: `tmr_wdt_shared`

## Requirements
- R1: With `reg_sel`=0 a write stores `reg_wdata` into the control byte, and with `reg_sel`=1 it loads the timer. `reg_rdata` returns the selected register combinationally. Control bits 7 and 6 are stored and read back but have no effect on counting.
- R2: After reset the control byte reads FFh, the timer reads 00h, and both `ovf_flag` and `wdt_timeout` are 0.
- R3: Control bit 5 selects the timer source: 0 selects `icyc_tick` and 1 selects the external pin. Events on the unselected source do not change the timer.
- R4: Control bit 4 selects the external edge: 0 counts low-to-high transitions and 1 counts high-to-low transitions. The pin passes through a two-flop synchroniser, and each qualifying edge gives exactly one count.
- R5: With control bit 3 at 0 the prescaler feeds the timer and divides by 2^(rate+1), where rate is control bits 2:0. This gives 2 for code 000 and 256 for code 111.
- R6: With control bit 3 at 1 the prescaler feeds the watchdog and divides by 2^rate, which is 1 to 128. The timer then advances once per selected source event.
- R7: With control bit 3 at 0 the watchdog advances once per `wdt_tick`, undivided.
- R8: The timer wraps from FFh to 00h and sets `ovf_flag`. The flag stays set until a timer write clears it.
- R9: A timer write clears the prescaler's partial count and leaves the rate setting unchanged.
- R10: `wdt_clr` resets the watchdog counter. When the prescaler is assigned to the watchdog, `wdt_clr` also clears the prescaler count.
- R11: `wdt_timeout` pulses high for exactly one cycle after 2^WDT_W watchdog increments with no clear in between.
- R12: A control write that changes bit 3 clears the prescaler count in that cycle, so no partial count reaches the new consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control byte, 1 timer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| icyc_tick | input | 1 | Internal instruction-cycle tick, one-cycle pulses |
| ext_clk_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Free-running watchdog tick, one-cycle pulses |
| wdt_clr | input | 1 | Watchdog clear strobe |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The bound checker watches several properties on every cycle. It checks that register writes land the next cycle and that the control byte holds between writes. It checks that the timer moves by at most one step per cycle, that the overflow flag stays sticky and is set on wrap, and that the timeout is a single-cycle pulse. Some behaviour only the bench scenarios can show, because it depends on counting many events: the division ratios for each owner, source and edge selection, and one count per synchronised edge. The same holds for the removal of partial prescaler counts on a timer write, on a watchdog clear and on a change of owner, and for the exact number of ticks before a timeout.

// File: rtl/tmrwdt_pkg.sv
package tmrwdt_pkg;
  localparam int BYTE_W = 8;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic             pu_off;      // stored only
    logic             irq_rise;    // stored only
    logic             src_ext;     // 1: external pin, 0: instruction tick
    logic             ext_fall;    // 1: high-to-low, 0: low-to-high
    logic             psc_to_wdt;  // 1: prescaler owned by watchdog
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '1;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tw_edge_detect.sv
module tw_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  always_comb begin
    if (fall_sel) evt = prev_q & ~sync_q[SYNC_STAGES-1];
    else          evt = ~prev_q & sync_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int STAGES = 8,
  localparam int SH_W = $clog2(STAGES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_in,
  input  logic            clr,
  input  logic [SH_W-1:0] shift,
  output logic            evt_out
);
  logic [STAGES-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask = ~({STAGES{1'b1}} << shift);
    evt_out = evt_in && !clr && ((cnt_q & mask) == mask);
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (evt_in) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_wdt_shared.sv
module tmr_wdt_shared
  import tmrwdt_pkg::*;
#(
  parameter int PSC_STAGES  = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SH_W = $clog2(PSC_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              icyc_tick,
  input  logic              ext_clk_pin,
  input  logic              wdt_tick,
  input  logic              wdt_clr,
  output logic              ovf_flag,
  output logic              wdt_timeout
);
  logic              rst_q;
  ctrl_t             ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] tmr_q, tmr_d;
  logic              ovf_q, ovf_d;
  logic [WDT_W-1:0]  wdt_q, wdt_d;
  logic              tmo_q, tmo_d;
  logic              ctrl_wr, tmr_wr, own_swap;
  logic              ext_evt, src_evt, psc_in, psc_out, psc_clr;
  logic              tmr_inc, wdt_inc;
  logic [SH_W-1:0]   psc_shift;

  tw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(rst_q)
  );

  tw_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_q), .pin(ext_clk_pin),
    .fall_sel(ctrl_q.ext_fall), .evt(ext_evt)
  );

  // Routing between the two consumers and the shared prescaler
  always_comb begin
    ctrl_wr  = reg_we && !reg_sel;
    tmr_wr   = reg_we && reg_sel;
    own_swap = ctrl_wr && (reg_wdata[3] != ctrl_q.psc_to_wdt);
    src_evt  = ctrl_q.src_ext ? ext_evt : icyc_tick;
    psc_in   = ctrl_q.psc_to_wdt ? wdt_tick : src_evt;
    psc_clr  = tmr_wr || own_swap || (wdt_clr && ctrl_q.psc_to_wdt);
    if (ctrl_q.psc_to_wdt) psc_shift = SH_W'(ctrl_q.rate);
    else                   psc_shift = SH_W'(ctrl_q.rate) + 1'b1;
    tmr_inc  = ctrl_q.psc_to_wdt ? src_evt : psc_out;
    wdt_inc  = ctrl_q.psc_to_wdt ? psc_out : wdt_tick;
  end

  tw_prescaler #(.STAGES(PSC_STAGES)) u_psc (
    .clk(clk), .rst_n(rst_q), .evt_in(psc_in), .clr(psc_clr),
    .shift(psc_shift), .evt_out(psc_out)
  );

  // Next-state logic
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(reg_wdata);

    tmr_d = tmr_q;
    ovf_d = ovf_q;
    if (tmr_wr) begin
      tmr_d = reg_wdata;
      ovf_d = 1'b0;
    end else if (tmr_inc) begin
      tmr_d = tmr_q + 1'b1;
      if (tmr_q == '1) ovf_d = 1'b1;
    end

    wdt_d = wdt_q;
    tmo_d = 1'b0;
    if (wdt_clr) begin
      wdt_d = '0;
    end else if (wdt_inc) begin
      wdt_d = wdt_q + 1'b1;
      tmo_d = (wdt_q == '1);
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q <= CTRL_RST;
      tmr_q  <= '0;
      ovf_q  <= 1'b0;
      wdt_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      tmr_q  <= tmr_d;
      ovf_q  <= ovf_d;
      wdt_q  <= wdt_d;
      tmo_q  <= tmo_d;
    end
  end

  assign reg_rdata   = reg_sel ? tmr_q : BYTE_W'(ctrl_q);
  assign ovf_flag    = ovf_q;
  assign wdt_timeout = tmo_q;
endmodule

// File: rtl/tmr_wdt_shared_chk.sv
module tmr_wdt_shared_chk (
  input logic       clk,
  input logic       rst_s,
  input logic       reg_we,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input logic [7:0] tmr_q,
  input logic [7:0] ctrl_q,
  input logic       ovf_flag,
  input logic       wdt_timeout
);
  p_tmr_write_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_we && reg_sel) |=> (tmr_q == $past(reg_wdata)));

  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_we && !reg_sel) |=> (ctrl_q == $past(reg_wdata)));

  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !(reg_we && !reg_sel) |=> $stable(ctrl_q));

  p_tmr_step_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !(reg_we && reg_sel) |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + 8'd1));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (ovf_flag && !(reg_we && reg_sel)) |=> ovf_flag);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (tmr_q == 8'hFF && !(reg_we && reg_sel)) |=> (tmr_q == 8'hFF || ovf_flag));

  p_tmo_pulse_r11: assert property (@(posedge clk) disable iff (!rst_s)
    wdt_timeout |=> !wdt_timeout);
endmodule

bind tmr_wdt_shared tmr_wdt_shared_chk u_chk (
  .clk(clk), .rst_s(rst_q), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .tmr_q(tmr_q), .ctrl_q(ctrl_q),
  .ovf_flag(ovf_flag), .wdt_timeout(wdt_timeout)
);

// File: tb/tmr_wdt_shared_test.sv
module tmr_wdt_shared_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       icyc_tick = 1'b0, ext_clk_pin = 1'b0, wdt_tick = 1'b0, wdt_clr = 1'b0;
  logic       ovf_flag, wdt_timeout;

  int checks = 0, failures = 0;
  int tmo_cnt = 0;
  logic tmo_prev = 1'b0, tmo_wide = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_wdt_shared uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .icyc_tick(icyc_tick),
    .ext_clk_pin(ext_clk_pin), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
    .ovf_flag(ovf_flag), .wdt_timeout(wdt_timeout)
  );

  always @(negedge clk) begin
    if (wdt_timeout) tmo_cnt <= tmo_cnt + 1;
    if (wdt_timeout && tmo_prev) tmo_wide <= 1'b1;
    tmo_prev <= wdt_timeout;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic icyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); icyc_tick = 1'b1;
      @(negedge clk); icyc_tick = 1'b0;
    end
  endtask

  task automatic wtick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_tick = 1'b1;
      @(negedge clk); wdt_tick = 1'b0;
    end
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk_pin = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk_pin = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wclr();
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // {control byte, instruction ticks, expected timer}
  localparam logic [31:0] VEC [7] = '{
    {8'h08, 16'd5,   8'd5},   // R6 prescaler on watchdog: 1:1
    {8'h0B, 16'd9,   8'd9},   // R6 rate ignored by timer
    {8'h00, 16'd7,   8'd3},   // R5 div 2
    {8'hC2, 16'd20,  8'd2},   // R5 div 8, bits 7:6 inert (R1)
    {8'h05, 16'd130, 8'd2},   // R5 div 64
    {8'h07, 16'd300, 8'd1},   // R5 div 256
    {8'h03, 16'd47,  8'd2}    // R5 div 16
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd(1'b0, d); chk("R2 ctrl reset", d, 8'hFF);
    rd(1'b1, d); chk("R2 timer reset", d, 8'h00);
    chk("R2 ovf reset", ovf_flag, 0);
    chk("R2 timeout reset", wdt_timeout, 0);

    // R1 control readback
    wr(1'b0, 8'hA8); rd(1'b0, d); chk("R1 ctrl readback", d, 8'hA8);

    // R5/R6 vector table
    foreach (VEC[i]) begin
      wr(1'b0, VEC[i][31:24]);
      wr(1'b1, 8'h00);
      icyc(int'(VEC[i][23:8]));
      settle();
      rd(1'b1, d);
      chk($sformatf("R5/R6 vector %0d", i), d, VEC[i][7:0]);
    end

    // R3/R4 external rising edge, instruction ticks ignored
    wr(1'b0, 8'h28); wr(1'b1, 8'h00);
    pin_pulses(3); settle();
    rd(1'b1, d); chk("R4 rising edges", d, 3);
    icyc(4); settle();
    rd(1'b1, d); chk("R3 icyc ignored on ext source", d, 3);

    // R4 falling edge
    wr(1'b0, 8'h38); wr(1'b1, 8'h00);
    pin_pulses(4); settle();
    rd(1'b1, d); chk("R4 falling edges", d, 4);

    // R3 internal source ignores pin
    wr(1'b0, 8'h08); wr(1'b1, 8'h00);
    pin_pulses(2); settle();
    rd(1'b1, d); chk("R3 pin ignored on internal source", d, 0);

    // R8 overflow
    wr(1'b1, 8'hFE); icyc(1); settle();
    rd(1'b1, d); chk("R8 at FF", d, 8'hFF);
    chk("R8 no flag yet", ovf_flag, 0);
    icyc(1); settle();
    rd(1'b1, d); chk("R8 wrap", d, 8'h00);
    chk("R8 flag set", ovf_flag, 1);
    icyc(3); settle();
    chk("R8 flag sticky", ovf_flag, 1);
    wr(1'b1, 8'h05); settle();
    chk("R8 flag cleared by write", ovf_flag, 0);

    // R9 timer write clears prescaler
    wr(1'b0, 8'h01); wr(1'b1, 8'h00);
    icyc(3); wr(1'b1, 8'h00); icyc(3); settle();
    rd(1'b1, d); chk("R9 partial count dropped", d, 0);
    icyc(1); settle();
    rd(1'b1, d); chk("R9 rate kept", d, 1);

    // R12 change of owner clears prescaler
    wr(1'b1, 8'h00); icyc(3);
    wr(1'b0, 8'h09); wr(1'b0, 8'h01);
    icyc(3); settle();
    rd(1'b1, d); chk("R12 no partial count after swap", d, 0);
    icyc(1); settle();
    rd(1'b1, d); chk("R12 full period after swap", d, 1);

    // R11 watchdog timeout, 1:1
    wr(1'b0, 8'h08); wclr(); base = tmo_cnt;
    wtick(255); settle();
    chk("R11 no timeout at 255", tmo_cnt - base, 0);
    wtick(1); settle();
    chk("R11 timeout at 256", tmo_cnt - base, 1);
    chk("R11 single-cycle pulse", tmo_wide, 0);

    // R10 clear prevents timeout
    wclr(); base = tmo_cnt;
    wtick(200); wclr(); wtick(100); settle();
    chk("R10 clear restarts watchdog", tmo_cnt - base, 0);

    // R6/R10 divide by 2 and prescaler cleared by wdt_clr
    wr(1'b0, 8'h09); wclr(); base = tmo_cnt;
    wtick(1); wclr(); wtick(511); settle();
    chk("R10 prescaler cleared by wdt_clr", tmo_cnt - base, 0);
    wtick(1); settle();
    chk("R6 watchdog div 2", tmo_cnt - base, 1);

    // R7 watchdog undivided while timer owns prescaler
    wr(1'b0, 8'h07); wclr(); base = tmo_cnt;
    wtick(255); settle();
    chk("R7 no timeout at 255", tmo_cnt - base, 0);
    wtick(1); settle();
    chk("R7 timeout at 256", tmo_cnt - base, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule